// File: doc/BRIEF.md
# Analog Input Mid-Value Voter

This block reduces one measurement, reported by three redundant acquisition channels, to a single trusted value. Each channel delivers a signed 16-bit fixed-point sample (read as 11 integer bits and 4 fractional bits, so 9.5 is the raw value 152) and a flag that marks the sample as usable. When all three samples are usable, the block outputs the middle one. When exactly two are usable, it builds a substitute third sample from the pair and then takes the middle of the three. The substitute is the smaller of the pair, the larger of the pair or their mean, as configured.

With a single usable sample or none, no vote is taken. The block then emits a fallback value, which is either a configured constant or the result of the most recent vote that used two or three samples. A lone usable sample is never passed through. Until the first such vote after reset, the "previous result" fallback reads as the configured constant.

The upstream logic presents a sample set together with a one-cycle strobe. The voted value, a 2-bit mode code and a valid pulse are registered and appear on the cycle after the strobe. They hold their values until the next strobe.

Top module: `midval_voter`

## Requirements
- R1: When a strobe arrives with all three flags set, the next cycle shows the median of the three signed samples and mode code 0.
- R2: When exactly two flags are set and the substitute selector is 0, the next cycle shows the smaller of the two usable samples and mode code 1.
- R3: When exactly two flags are set and the substitute selector is 1, the next cycle shows the larger of the two usable samples and mode code 1.
- R4: When exactly two flags are set and the selector is 2 or 3, the next cycle shows floor((p+q)/2) of the two usable samples, computed with a 17-bit sum, and mode code 1.
- R5: When one flag is set, the mode code is 2. When no flag is set, the mode code is 3. In both cases the output is the fallback value, and any single usable sample is ignored.
- R6: When the fallback selector (`cfg_dflt_last`) is 0, the fallback value is `cfg_dflt_const` as sampled with the strobe.
- R7: When the fallback selector is 1, the fallback value is the result of the latest strobe that had two or three flags set. If no such strobe has occurred since reset, the fallback value is `cfg_dflt_const`.
- R8: A strobe with fewer than two flags set leaves the remembered previous result unchanged.
- R9: Results are registered. `out_valid` is high only in the cycle after a strobe, and `out_value` and `out_mode` hold their values while no strobe arrives. Back-to-back strobes each produce a result.
- R10: After reset, `out_valid` is 0, `out_value` is 0 and `out_mode` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_strobe | input | 1 | Sample set present this cycle |
| val_a | input | 16 | Channel A sample, signed fixed point |
| val_b | input | 16 | Channel B sample, signed fixed point |
| val_c | input | 16 | Channel C sample, signed fixed point |
| vld_a | input | 1 | Channel A sample usable |
| vld_b | input | 1 | Channel B sample usable |
| vld_c | input | 1 | Channel C sample usable |
| cfg_dup_sel | input | 2 | Substitute: 0 minimum, 1 maximum, 2/3 mean |
| cfg_dflt_last | input | 1 | Fallback: 0 constant, 1 previous voted result |
| cfg_dflt_const | input | 16 | Fallback constant, signed fixed point |
| out_valid | output | 1 | Result pulse, one cycle after the strobe |
| out_value | output | 16 | Voted or fallback value |
| out_mode | output | 2 | 0 three usable, 1 two usable, 2 one usable, 3 none |

## Verification
In one clock edge, a vote that uses two usable samples writes the remembered result while also updating the output. A fallback strobe on the very next cycle must read that fresh value. The bench provokes this by issuing a two-channel vote and a one-channel strobe in back-to-back cycles with the "previous result" fallback selected. It judges the second result against the substitute value that it computed arithmetically for the first strobe. The exhaustive sweep also alternates the fallback selector, so fallback reads follow remembered-result writes under every flag pattern.

// File: rtl/midval_pkg.sv
package midval_pkg;
  typedef enum logic [1:0] {
    MODE_TRIPLE = 2'd0,
    MODE_DUPLEX = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_NONE   = 2'd3
  } vote_mode_e;

  typedef enum logic [1:0] {
    SUB_MIN  = 2'd0,
    SUB_MAX  = 2'd1,
    SUB_AVG  = 2'd2,
    SUB_RSVD = 2'd3
  } sub_sel_e;
endpackage

// File: rtl/midval_rst_sync.sv
module midval_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/midval_pair_pick.sv
module midval_pair_pick #(
  parameter int W   = 16,
  parameter int NCH = 3,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic [NCH-1:0][W-1:0] ch,
  input  logic [NCH-1:0]        vld,
  output logic [CW-1:0]         nvalid,
  output logic [W-1:0]          low_pick,
  output logic [W-1:0]          high_pick
);
  logic [NCH-1:0][CW-1:0] cnt_chain;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_cnt
      if (g == 0) begin : g_first
        assign cnt_chain[g] = CW'(vld[g]);
      end else begin : g_rest
        assign cnt_chain[g] = cnt_chain[g-1] + CW'(vld[g]);
      end
    end
  endgenerate

  assign nvalid = cnt_chain[NCH-1];

  always_comb begin
    low_pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (vld[i]) low_pick = ch[i];
    end
  end

  always_comb begin
    high_pick = '0;
    for (int i = 0; i < NCH; i++) begin
      if (vld[i]) high_pick = ch[i];
    end
  end
endmodule

// File: rtl/midval_duplex.sv
module midval_duplex
  import midval_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] p,
  input  logic signed [W-1:0] q,
  input  logic [1:0]          sel,
  output logic signed [W-1:0] sub
);
  logic signed [W:0]   sum_wide;
  logic signed [W-1:0] mean_v;
  logic signed [W-1:0] lo_v;
  logic signed [W-1:0] hi_v;

  assign sum_wide = $signed({p[W-1], p}) + $signed({q[W-1], q});
  assign mean_v   = sum_wide[W:1];
  assign lo_v     = (p < q) ? p : q;
  assign hi_v     = (p < q) ? q : p;

  always_comb begin
    case (sub_sel_e'(sel))
      SUB_MIN: sub = lo_v;
      SUB_MAX: sub = hi_v;
      default: sub = mean_v;
    endcase
  end

  always_comb begin
    if (!$isunknown({p, q, sel})) begin
      // R4
      sub_in_range_chk: assert (sub >= lo_v && sub <= hi_v)
        else $error("substitute value outside the pair range");
    end
  end
endmodule

// File: rtl/midval_median3.sv
module midval_median3 #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] y,
  input  logic signed [W-1:0] z,
  output logic signed [W-1:0] med
);
  logic signed [W-1:0] xy_lo;
  logic signed [W-1:0] xy_hi;
  logic signed [W-1:0] hi_z_lo;

  assign xy_lo   = (x < y) ? x : y;
  assign xy_hi   = (x < y) ? y : x;
  assign hi_z_lo = (xy_hi < z) ? xy_hi : z;
  assign med     = (xy_lo < hi_z_lo) ? hi_z_lo : xy_lo;

  always_comb begin
    if (!$isunknown({x, y, z})) begin
      // R1
      med_member_chk: assert ((med == x || med == y || med == z) &&
                              !(med > x && med > y) && !(med < x && med < y))
        else $error("median selection is not the middle value");
    end
  end
endmodule

// File: rtl/midval_voter.sv
module midval_voter
  import midval_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 3,
  localparam int CW = $clog2(NCH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_strobe,
  input  logic signed [W-1:0] val_a,
  input  logic signed [W-1:0] val_b,
  input  logic signed [W-1:0] val_c,
  input  logic                vld_a,
  input  logic                vld_b,
  input  logic                vld_c,
  input  logic [1:0]          cfg_dup_sel,
  input  logic                cfg_dflt_last,
  input  logic signed [W-1:0] cfg_dflt_const,
  output logic                out_valid,
  output logic signed [W-1:0] out_value,
  output logic [1:0]          out_mode
);
  logic rst_sync_n;

  midval_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [NCH-1:0][W-1:0] ch_bus;
  logic [NCH-1:0]        vld_bus;
  logic [CW-1:0]         nvalid;
  logic [W-1:0]          low_pick;
  logic [W-1:0]          high_pick;
  logic signed [W-1:0]   sub_v;
  logic signed [W-1:0]   med_x;
  logic signed [W-1:0]   med_y;
  logic signed [W-1:0]   med_z;
  logic signed [W-1:0]   med_v;

  assign ch_bus  = {val_c, val_b, val_a};
  assign vld_bus = {vld_c, vld_b, vld_a};

  midval_pair_pick #(.W(W), .NCH(NCH)) u_pick (
    .ch        (ch_bus),
    .vld       (vld_bus),
    .nvalid    (nvalid),
    .low_pick  (low_pick),
    .high_pick (high_pick)
  );

  midval_duplex #(.W(W)) u_dup (
    .p   ($signed(low_pick)),
    .q   ($signed(high_pick)),
    .sel (cfg_dup_sel),
    .sub (sub_v)
  );

  logic full_set;
  logic vote_ok;
  assign full_set = (nvalid == CW'(NCH));
  assign vote_ok  = (nvalid >= CW'(2));

  assign med_x = full_set ? val_a : $signed(low_pick);
  assign med_y = full_set ? val_b : $signed(high_pick);
  assign med_z = full_set ? val_c : sub_v;

  midval_median3 #(.W(W)) u_med (
    .x   (med_x),
    .y   (med_y),
    .z   (med_z),
    .med (med_v)
  );

  // Registered state
  logic                valid_q, valid_d;
  logic signed [W-1:0] value_q, value_d;
  vote_mode_e          mode_q, mode_d;
  logic signed [W-1:0] last_q, last_d;
  logic                seen_q, seen_d;

  logic signed [W-1:0] fallback_v;
  vote_mode_e          mode_now;

  assign fallback_v = (cfg_dflt_last && seen_q) ? last_q : cfg_dflt_const;

  always_comb begin
    if (full_set)          mode_now = MODE_TRIPLE;
    else if (vote_ok)      mode_now = MODE_DUPLEX;
    else if (nvalid != '0) mode_now = MODE_SINGLE;
    else                   mode_now = MODE_NONE;
  end

  always_comb begin
    valid_d = in_strobe;
    value_d = value_q;
    mode_d  = mode_q;
    last_d  = last_q;
    seen_d  = seen_q;
    if (in_strobe) begin
      mode_d  = mode_now;
      value_d = vote_ok ? med_v : fallback_v;
      if (vote_ok) begin
        last_d = med_v;
        seen_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      value_q <= '0;
      mode_q  <= MODE_NONE;
      last_q  <= '0;
      seen_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      value_q <= value_d;
      mode_q  <= mode_d;
      last_q  <= last_d;
      seen_q  <= seen_d;
    end
  end

  assign out_valid = valid_q;
  assign out_value = value_q;
  assign out_mode  = mode_q;

  // R1
  tri_mode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_strobe && vld_a && vld_b && vld_c) |=> (out_valid && out_mode == 2'd0));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_strobe |=> (!out_valid && $stable(out_value) && $stable(out_mode)));

  // R6
  const_fallback_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_strobe && !vote_ok && !cfg_dflt_last) |=> (out_value == $past(cfg_dflt_const)));

  // R7
  last_fallback_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_strobe && !vote_ok && cfg_dflt_last && seen_q) |=> (out_value == $past(last_q)));

  // R8
  last_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_strobe && !vote_ok) |=> $stable(last_q));
endmodule

// File: tb/midval_voter_tb.sv
module midval_voter_tb;
  logic               clk;
  logic               rst_n;
  logic               in_strobe;
  logic signed [15:0] val_a, val_b, val_c;
  logic               vld_a, vld_b, vld_c;
  logic [1:0]         cfg_dup_sel;
  logic               cfg_dflt_last;
  logic signed [15:0] cfg_dflt_const;
  logic               out_valid;
  logic signed [15:0] out_value;
  logic [1:0]         out_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_last = 0;
  bit m_seen = 0;

  midval_voter u_dut (
    .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe),
    .val_a(val_a), .val_b(val_b), .val_c(val_c),
    .vld_a(vld_a), .vld_b(vld_b), .vld_c(vld_c),
    .cfg_dup_sel(cfg_dup_sel), .cfg_dflt_last(cfg_dflt_last),
    .cfg_dflt_const(cfg_dflt_const),
    .out_valid(out_valid), .out_value(out_value), .out_mode(out_mode)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int floor_half(int s);
    if (s >= 0) return s / 2;
    return -((-s + 1) / 2);
  endfunction

  function automatic int mid3(int x, int y, int z);
    if ((x <= y && y <= z) || (z <= y && y <= x)) return y;
    if ((y <= x && x <= z) || (z <= x && x <= y)) return x;
    return z;
  endfunction

  // Expected value and mode; updates the model of the remembered result
  task automatic expect_vote(input int a, input int b, input int c, input bit [2:0] m,
                             input int sel, input bit dl, input int dc,
                             output int ev, output int em, output string tag);
    int n;
    int p, q, sub;
    n = m[0] + m[1] + m[2];
    p = 0; q = 0;
    if (n == 2) begin
      if (!m[0])      begin p = b; q = c; end
      else if (!m[1]) begin p = a; q = c; end
      else            begin p = a; q = b; end
    end
    if (n == 3) begin
      ev = mid3(a, b, c); em = 0; tag = "R1";
    end else if (n == 2) begin
      em = 1;
      if (sel == 0)      begin sub = (p < q) ? p : q; tag = "R2"; end
      else if (sel == 1) begin sub = (p < q) ? q : p; tag = "R3"; end
      else               begin sub = floor_half(p + q); tag = "R4"; end
      ev = sub;
    end else begin
      em = (n == 1) ? 2 : 3;
      ev = (dl && m_seen) ? m_last : dc;
      tag = dl ? "R5/R7" : "R5/R6";
    end
    if (n >= 2) begin m_last = ev; m_seen = 1; end
  endtask

  task automatic drive(int a, int b, int c, bit [2:0] m, int sel, bit dl, int dc);
    val_a = 16'(a); val_b = 16'(b); val_c = 16'(c);
    vld_a = m[0]; vld_b = m[1]; vld_c = m[2];
    cfg_dup_sel = 2'(sel); cfg_dflt_last = dl; cfg_dflt_const = 16'(dc);
    in_strobe = 1'b1;
  endtask

  task automatic vote(int a, int b, int c, bit [2:0] m, int sel, bit dl, int dc);
    int ev, em;
    string tag;
    @(negedge clk);
    drive(a, b, c, m, sel, dl, dc);
    expect_vote(a, b, c, m, sel, dl, dc, ev, em, tag);
    @(negedge clk);
    in_strobe = 1'b0;
    check({tag, " value"}, int'(out_value), ev);
    check({tag, " mode"}, int'(out_mode), em);
    check("R9 valid pulse", int'(out_valid), 1);
  endtask

  int vals[5] = '{-32768, -17, 0, 152, 32767};

  initial begin
    int ev1, em1, ev2, em2;
    string t1, t2;
    int held;
    rst_n = 0; in_strobe = 0;
    val_a = 0; val_b = 0; val_c = 0; vld_a = 0; vld_b = 0; vld_c = 0;
    cfg_dup_sel = 0; cfg_dflt_last = 0; cfg_dflt_const = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", int'(out_valid), 0);
    check("R10 value", int'(out_value), 0);
    check("R10 mode", int'(out_mode), 3);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R10 valid after release", int'(out_valid), 0);

    // R7: previous-result fallback before any vote reads the constant; lone sample ignored (R5)
    vote(500, 0, 0, 3'b001, 2, 1, 141);
    // Worked examples: 8,9,10 -> 9 ; mean pairs 9.5 and 9 ; constant 8.8
    vote(128, 144, 160, 3'b111, 2, 0, 141);
    vote(0, 144, 160, 3'b110, 2, 0, 141);
    vote(128, 0, 160, 3'b101, 2, 0, 141);
    vote(0, 0, 160, 3'b100, 2, 0, 141);
    vote(0, 0, 0, 3'b000, 2, 0, 141);
    // R4 negative mean rounds toward minus infinity; selector 3 acts as mean
    vote(-1, 0, 0, 3'b011, 3, 0, 141);

    // R8: fallback strobes must not disturb the remembered result
    vote(40, 0, -20, 3'b101, 1, 0, 141);
    vote(999, 0, 0, 3'b001, 0, 0, 77);
    vote(0, 0, 0, 3'b000, 0, 1, 77);
    check("R8 remembered result kept", int'(out_value), 40);

    // R9: idle cycle holds outputs while inputs change
    held = int'(out_value);
    @(negedge clk);
    drive(1, 2, 3, 3'b111, 0, 0, 5);
    in_strobe = 1'b0;
    @(negedge clk);
    check("R9 idle valid", int'(out_valid), 0);
    check("R9 idle value", int'(out_value), held);
    check("R9 idle mode", int'(out_mode), 3);

    // R7/R9 back-to-back: a vote then an immediate fallback strobe reading it
    @(negedge clk);
    drive(-300, 0, 700, 3'b101, 2, 1, 9);
    expect_vote(-300, 0, 700, 3'b101, 2, 1, 9, ev1, em1, t1);
    @(negedge clk);
    drive(0, 555, 0, 3'b010, 0, 1, 9);
    expect_vote(0, 555, 0, 3'b010, 0, 1, 9, ev2, em2, t2);
    check("R9 first back-to-back value", int'(out_value), ev1);
    @(negedge clk);
    in_strobe = 1'b0;
    check("R7 back-to-back fallback", int'(out_value), ev2);
    check("R7 back-to-back expected 200", ev2, 200);
    check("R9 second pulse", int'(out_valid), 1);

    // Exhaustive sweep over flags, selector, fallback source and sample set
    for (int dl = 0; dl < 2; dl++)
      for (int sel = 0; sel < 4; sel++)
        for (int m = 0; m < 8; m++)
          for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
              for (int k = 0; k < 5; k++)
                vote(vals[i], vals[j], vals[k], 3'(m), sel, dl[0], vals[(i + k) % 5]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule